// File: doc/BRIEF.md
# Serial EEPROM to SRAM Loader

This block copies the complete contents of an external serial EEPROM into an on-chip SRAM. Once it sees a rising edge on `load_en`, it reads the device one 16-bit word at a time. For each word it pulls chip select low and sends a command frame. The frame is a start bit, a two-bit read code and the word address. The block then clocks in the 16-bit word and writes it into the SRAM at the same address.

The serial clock runs at half the system clock and rests low. Outgoing bits change while the serial clock is low. Incoming bits are captured on the rising serial edge, most significant bit first. Three pieces share the work: a small state machine, a pair of shift registers (one for the outgoing command, one for the incoming word), and counters for bits, words and the chip-select gap. When the last word has been written, the block raises `done` and waits for the next rising edge of `load_en`.

Top module: `spi_rom_loader`

## Requirements
- R1: After reset, and until `load_en` first rises, `spi_cs_n` is 1, `spi_sclk` is 0, `sram_we` is 0 and `done` is 0. Toggling `spi_miso` has no effect in this period.
- R2: Each frame sent on `spi_mosi` while `spi_cs_n` is 0 begins with bit 1, then the read code 1,0, then the word address MSB first (ADDR_W bits). `spi_mosi` only changes when `spi_sclk` falls.
- R3: `spi_sclk` is high for one system cycle and low for one system cycle. Each chip-select-low window lasts exactly 2*(3+ADDR_W+DATA_W) system cycles.
- R4: Each frame has exactly 3+ADDR_W+DATA_W rising `spi_sclk` edges. The DATA_W data bits follow the address and are sampled from `spi_miso` on rising edges, MSB first.
- R5: Each received word appears on `sram_wdata` with its address on `sram_addr` while `sram_we` is high. `sram_we` is high for exactly one system cycle per word, and only while `spi_cs_n` is 1.
- R6: One load reads addresses 0 to 2^ADDR_W-1 in ascending order. It produces exactly 2^ADDR_W frames and 2^ADDR_W writes. The default of 1024 words covers a 2048-byte device.
- R7: Between two frames, `spi_cs_n` stays at 1 for at least 4 system cycles (two serial clock periods).
- R8: `load_en` acts on its rising edge only. A rising edge during a load does not restart or disturb it. Holding `load_en` high after a load does not start another.
- R9: `done` rises after the last word is written and stays high until the next rising edge of `load_en`. That edge clears `done` and starts a new full load.
- R10: `spi_sclk` is 0 whenever `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load request; its rising edge starts a copy |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_sclk | output | 1 | Serial clock, half the system rate, rests low |
| spi_mosi | output | 1 | Serial command data to the EEPROM |
| spi_miso | input | 1 | Serial read data from the EEPROM |
| sram_we | output | 1 | SRAM write strobe, one cycle per word |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| done | output | 1 | Copy complete; held until the next load request |

## Verification
A behavioural EEPROM model answers every frame with a word computed from the address and a per-load seed. Two full sweeps with different seeds show that every SRAM location is rewritten by a new load, not left over from the previous one. The model also decodes each header, so a wrong start bit, read code or address order shows up as a mismatch against the expected ascending address. A second rising edge of `load_en` in the middle of a sweep, and `load_en` held high after completion, separate a level-sensitive start from an edge-detected one. Toggling `spi_miso` before the first request shows whether the idle block reacts to the serial lines.

// File: rtl/srl_pkg.sv
package srl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_WRITE,
      ST_GAP
   } ld_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/srl_counter.sv
module srl_counter #(
   parameter int W     = 4,
   parameter int LIMIT = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         at_limit
);

   if (LIMIT >= (1 << W)) begin : g_bad_limit
      $error("srl_counter: LIMIT does not fit in W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign at_limit = (cnt == W'(LIMIT));

endmodule

// File: rtl/srl_shifter.sv
module srl_shifter #(
   parameter int W         = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] par_in,
   input  logic         shift,
   input  logic         sin,
   output logic [W-1:0] q
);

   logic [W-1:0] nxt;

   if (W < 2) begin : g_bad_width
      $error("srl_shifter: W must be at least 2");
   end

   if (MSB_FIRST) begin : g_left
      assign nxt = {q[W-2:0], sin};
   end else begin : g_right
      assign nxt = {sin, q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= par_in;
      else if (shift)  q <= nxt;
   end

endmodule

// File: rtl/spi_rom_loader.sv
module spi_rom_loader
   import srl_pkg::*;
#(
   parameter int         ADDR_W  = 10,
   parameter int         DATA_W  = 16,
   parameter logic [1:0] RD_CODE = 2'b10,
   parameter int         GAP_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata,
   output logic              done
);

   localparam int WORDS    = 1 << ADDR_W;
   localparam int CMD_BITS = 3 + ADDR_W;
   localparam int BIT_W    = $clog2(max2(CMD_BITS, DATA_W) + 1);
   localparam int GAP_W    = $clog2(GAP_CYC + 1);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("spi_rom_loader: ADDR_W out of range");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("spi_rom_loader: DATA_W must be at least 2");
   end
   if (GAP_CYC < 3) begin : g_bad_gap
      $error("spi_rom_loader: GAP_CYC must give two serial periods of deselect");
   end

   ld_state_e st_q, st_d;
   logic      ph_q, ph_d;
   logic      le_q, cs_n_q, sclk_q, done_q;

   logic                start, next_word, cmd_load, in_xfer_d;
   logic [CMD_BITS-1:0] cmd_val, cmd_q;
   logic [DATA_W-1:0]   data_q;
   logic [ADDR_W-1:0]   word_cnt;
   logic                word_last;
   logic [BIT_W-1:0]    bit_cnt;
   logic                data_last, cmd_last;
   logic [GAP_W-1:0]    gap_cnt_unused;
   logic                gap_last;
   logic                cmd_unused;

   assign start     = load_en & ~le_q & (st_q == ST_IDLE);
   assign next_word = (st_q == ST_GAP) & gap_last & ~word_last;
   assign cmd_load  = start | next_word;
   assign cmd_val   = {1'b1, RD_CODE, (start ? '0 : word_cnt + 1'b1)};
   assign cmd_last  = (bit_cnt == BIT_W'(CMD_BITS - 1));

   always_comb begin
      st_d = st_q;
      ph_d = 1'b0;
      case (st_q)
         ST_IDLE:  if (start) st_d = ST_CMD;
         ST_CMD: begin
            ph_d = ~ph_q;
            if (ph_q && cmd_last) st_d = ST_DATA;
         end
         ST_DATA: begin
            ph_d = ~ph_q;
            if (ph_q && data_last) st_d = ST_WRITE;
         end
         ST_WRITE: st_d = ST_GAP;
         ST_GAP:   if (gap_last) st_d = word_last ? ST_IDLE : ST_CMD;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign in_xfer_d = (st_d == ST_CMD) || (st_d == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= 1'b0;
         le_q   <= 1'b0;
         cs_n_q <= 1'b1;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         le_q   <= load_en;
         cs_n_q <= ~in_xfer_d;
         sclk_q <= in_xfer_d & ph_d;
         if (start)
            done_q <= 1'b0;
         else if ((st_q == ST_GAP) && gap_last && word_last)
            done_q <= 1'b1;
      end
   end

   srl_shifter #(.W(CMD_BITS), .MSB_FIRST(1'b1)) u_cmd_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cmd_load),
      .par_in (cmd_val),
      .shift  ((st_q == ST_CMD) & ph_q),
      .sin    (1'b0),
      .q      (cmd_q)
   );

   srl_shifter #(.W(DATA_W), .MSB_FIRST(1'b1)) u_data_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (1'b0),
      .par_in ('0),
      .shift  ((st_q == ST_DATA) & ~ph_q),
      .sin    (spi_miso),
      .q      (data_q)
   );

   srl_counter #(.W(BIT_W), .LIMIT(DATA_W - 1)) u_bit_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cmd_load | ((st_q == ST_CMD) & ph_q & cmd_last)),
      .inc      (((st_q == ST_CMD) | (st_q == ST_DATA)) & ph_q),
      .cnt      (bit_cnt),
      .at_limit (data_last)
   );

   srl_counter #(.W(ADDR_W), .LIMIT(WORDS - 1)) u_word_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .inc      (next_word),
      .cnt      (word_cnt),
      .at_limit (word_last)
   );

   srl_counter #(.W(GAP_W), .LIMIT(GAP_CYC - 1)) u_gap_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (st_q == ST_WRITE),
      .inc      (st_q == ST_GAP),
      .cnt      (gap_cnt_unused),
      .at_limit (gap_last)
   );

   assign cmd_unused = ^cmd_q[CMD_BITS-2:0];

   assign spi_cs_n   = cs_n_q;
   assign spi_sclk   = sclk_q;
   assign spi_mosi   = cmd_q[CMD_BITS-1];
   assign sram_we    = (st_q == ST_WRITE);
   assign sram_addr  = word_cnt;
   assign sram_wdata = data_q;
   assign done       = done_q;

endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
   parameter int ADDR_W  = 10,
   parameter int GAP_MIN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              mosi,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic              done
);

   logic [ADDR_W-1:0] prev_addr;
   logic              seen;
   logic [3:0]        hi_cnt;
   logic              framed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_addr <= '0;
         seen      <= 1'b0;
         hi_cnt    <= '0;
         framed    <= 1'b0;
      end else begin
         if (we) begin
            prev_addr <= addr;
            seen      <= 1'b1;
         end
         if (cs_n) hi_cnt <= (hi_cnt == 4'hF) ? hi_cnt : hi_cnt + 4'd1;
         else      hi_cnt <= '0;
         if (!cs_n) framed <= 1'b1;
      end
   end

   a_r10_sclk_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r3_sclk_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |=> !sclk);

   a_r2_mosi_holds_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   a_r5_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   a_r5_we_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> cs_n);

   a_r6_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !seen) |-> (addr == '0));

   a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (we && seen) |-> (addr == ADDR_W'(prev_addr + 1'b1)));

   a_r7_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (framed && $fell(cs_n)) |-> (hi_cnt >= 4'(GAP_MIN)));

   a_r9_done_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !we));

endmodule

bind spi_rom_loader srl_checker #(.ADDR_W(ADDR_W), .GAP_MIN(4)) u_srl_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .cs_n (spi_cs_n),
   .sclk (spi_sclk),
   .mosi (spi_mosi),
   .we   (sram_we),
   .addr (sram_addr),
   .done (done)
);

// File: tb/tb_spi_rom_loader.sv
`timescale 1ns/1ps
module tb_spi_rom_loader;

   localparam int AW    = 6;
   localparam int DW    = 16;
   localparam int WORDS = 1 << AW;
   localparam int CMDB  = 3 + AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic          spi_miso = 1'b0;
   logic          spi_cs_n, spi_sclk, spi_mosi, sram_we, done;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_wdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   spi_rom_loader #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .sram_we(sram_we), .sram_addr(sram_addr),
      .sram_wdata(sram_wdata), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   function automatic logic [DW-1:0] rom_val(input int a, input int s);
      return DW'((a * 40503) ^ (s * 12345) ^ (a << 9));
   endfunction

   // EEPROM model
   int            seed = 1;
   int            rx_cnt = 0;
   int            out_cnt = 0;
   int            frames = 0;
   int            exp_addr = 0;
   bit            in_frame = 1'b0;
   logic [CMDB-1:0] hdr = '0;
   logic [DW-1:0] cur_word = '0;

   always @(negedge spi_cs_n) begin
      in_frame = 1'b1;
      rx_cnt   = 0;
      out_cnt  = 0;
   end

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      if (rx_cnt < CMDB) hdr = {hdr[CMDB-2:0], spi_mosi};
      rx_cnt++;
      if (rx_cnt == CMDB) begin
         chk(hdr[CMDB-1] == 1'b1, "R2 start bit", int'(hdr[CMDB-1]), 1);
         chk(hdr[CMDB-2 -: 2] == 2'b10, "R2 read code", int'(hdr[CMDB-2 -: 2]), 2);
         chk(int'(hdr[AW-1:0]) == exp_addr % WORDS, "R6 frame address",
             int'(hdr[AW-1:0]), exp_addr % WORDS);
         cur_word = rom_val(int'(hdr[AW-1:0]), seed);
      end
   end

   always @(negedge spi_sclk) if (!spi_cs_n && rx_cnt >= CMDB && out_cnt < DW) begin
      spi_miso = cur_word[DW-1-out_cnt];
      out_cnt++;
   end

   always @(posedge spi_cs_n) if (in_frame) begin
      chk(rx_cnt == CMDB + DW, "R4 rising edges per frame", rx_cnt, CMDB + DW);
      frames++;
      exp_addr++;
      in_frame = 1'b0;
   end

   // SRAM model and line timing
   logic [DW-1:0] mem [WORDS];
   int  writes = 0;
   bit  we_prev = 1'b0;
   bit  cs_prev = 1'b1;
   int  low_len = 0;
   int  hi_len  = 0;

   always @(negedge clk) if (rst_n) begin
      if (sram_we) begin
         chk(!we_prev, "R5 single-cycle write", 1, 0);
         chk(int'(sram_addr) == writes % WORDS, "R6 write order", int'(sram_addr), writes % WORDS);
         chk(sram_wdata == rom_val(int'(sram_addr), seed), "R5 write data",
             int'(sram_wdata), int'(rom_val(int'(sram_addr), seed)));
         mem[sram_addr] = sram_wdata;
         writes++;
      end
      we_prev = sram_we;
      if (spi_cs_n && spi_sclk) chk(1'b0, "R10 sclk while deselected", 1, 0);
      if (!spi_cs_n) begin
         if (cs_prev) begin
            if (frames > 0) chk(hi_len >= 4, "R7 deselect gap", hi_len, 4);
            low_len = 0;
         end
         low_len++;
      end else begin
         if (!cs_prev) begin
            chk(low_len == 2 * (CMDB + DW), "R3 frame length", low_len, 2 * (CMDB + DW));
            hi_len = 0;
         end
         hi_len++;
      end
      cs_prev = spi_cs_n;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL R9 watchdog: actual %0d cycles expected completion before %0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, req, int'(done), 1);
   endtask

   task automatic check_mem(input string req);
      for (int a = 0; a < WORDS; a++)
         chk(mem[a] == rom_val(a, seed), req, int'(mem[a]), int'(rom_val(a, seed)));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 1'b1, "R1 cs_n after reset", int'(spi_cs_n), 1);
      chk(spi_sclk == 1'b0, "R1 sclk after reset", int'(spi_sclk), 0);
      chk(sram_we == 1'b0, "R1 we after reset", int'(sram_we), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      // R1 idle with toggling serial input
      for (int i = 0; i < 60; i++) begin
         spi_miso = i[0];
         @(negedge clk);
      end
      chk(frames == 0, "R1 no frame while idle", frames, 0);
      chk(writes == 0, "R1 no write while idle", writes, 0);
      chk(done == 1'b0, "R1 done idle", int'(done), 0);

      // first load, with a second rising edge mid-sweep (R8)
      seed = 1;
      load_en = 1'b1;
      repeat (1000) @(negedge clk);
      load_en = 1'b0;
      repeat (3) @(negedge clk);
      load_en = 1'b1;
      wait_done("R9 done after first load");
      chk(frames == WORDS, "R6 frames in first load", frames, WORDS);
      chk(writes == WORDS, "R8 mid-load edge ignored, writes", writes, WORDS);
      check_mem("R4 first load contents");

      // R8 level held high does not restart; R9 done holds
      repeat (300) @(negedge clk);
      chk(frames == WORDS, "R8 held level no restart", frames, WORDS);
      chk(done == 1'b1, "R9 done held", int'(done), 1);

      // second load with new contents
      load_en = 1'b0;
      repeat (2) @(negedge clk);
      seed = 2;
      exp_addr = 0;
      writes = 0;
      frames = 0;
      load_en = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R9 done cleared by new edge", int'(done), 0);
      wait_done("R9 done after second load");
      chk(frames == WORDS, "R6 frames in second load", frames, WORDS);
      chk(writes == WORDS, "R6 writes in second load", writes, WORDS);
      check_mem("R5 second load contents");
      load_en = 1'b0;
      repeat (10) @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule